// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel data buses, called side A and side B, and moves data between them in either direction. Each side owns a holding register. That register samples its own bus when the side's capture strobe goes from low to high. The strobes are sampled on one shared system clock, so each strobe acts as an edge-detected clock enable and not as a clock of its own.

A low-active drive enable and a direction input choose which side, if any, the block drives. For each direction a path select chooses the value placed on the driven bus: either the live value of the opposite bus, passed straight through, or the opposite side's holding register. Capture never depends on the enable, direction or select inputs, so a register can be loaded while the block is isolated and read out later in stored mode.

Tri-state pins are modelled as a separate input vector, output vector and output-enable vector for each side. This keeps the block synthesizable inside an FPGA fabric.

Top module: `bus_xcvr_reg`

## Requirements
- R1: The A holding register loads `a_in` at a clock edge where `cap_a` is sampled high and was sampled low at the previous edge. The loaded value can be read through the stored path from the next cycle on.
- R2: The B holding register loads `b_in` at a clock edge where `cap_b` is sampled high and was sampled low at the previous edge, by the same rule as R1.
- R3: Capture into either register takes place whatever the values of `oe_n`, `dir_a2b`, `sel_a2b` and `sel_b2a`, including while both sides are isolated.
- R4: While `oe_n` is 1, `a_oe` and `b_oe` are all zeros and `a_out` and `b_out` are zero.
- R5: While `oe_n` is 0 and `dir_a2b` is 1, side B is driven (`b_oe` all ones) and side A is not driven (`a_oe` zero, `a_out` zero).
- R6: While `oe_n` is 0 and `dir_a2b` is 0, side A is driven (`a_oe` all ones) and side B is not driven (`b_oe` zero, `b_out` zero).
- R7: While B is driven, `b_out` equals the live `a_in` in the same cycle when `sel_a2b` is 0, and equals the A register, without inversion, when `sel_a2b` is 1.
- R8: While A is driven, `a_out` equals the live `b_in` in the same cycle when `sel_b2a` is 0, and equals the B register, without inversion, when `sel_b2a` is 1.
- R9: Each output-enable vector is either all ones or all zeros, and a side's data output is zero whenever that side is not driven.
- R10: A clock edge with `rst_n` low clears both holding registers to zero and clears the strobe edge history.
- R11: A strobe held high across several edges loads its register only once; later changes on the bus do not reach the register until the strobe has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 8 | Value sensed on bus A |
| a_out | output | 8 | Value to drive onto bus A |
| a_oe | output | 8 | Per-bit drive enable for bus A |
| b_in | input | 8 | Value sensed on bus B |
| b_out | output | 8 | Value to drive onto bus B |
| b_oe | output | 8 | Per-bit drive enable for bus B |
| cap_a | input | 1 | Capture strobe for the A register, rising-edge detected |
| cap_b | input | 1 | Capture strobe for the B register, rising-edge detected |
| oe_n | input | 1 | Drive enable, active low; high isolates both sides |
| dir_a2b | input | 1 | 1 drives B from the A side, 0 drives A from the B side |
| sel_a2b | input | 1 | B source: 0 live A bus, 1 A register |
| sel_b2a | input | 1 | A source: 0 live B bus, 1 B register |

## Verification
On every cycle, the assertions check four things: that at most one side is driven, that isolation forces both enables and both outputs to zero, that each enable vector is uniform, and that the stored paths present the register contents. They also check that a strobe edge loads the bus value and that a held strobe leaves its register unchanged. Only the bench scenarios can show the end-to-end effects. These are: a value captured while isolated coming out later in stored mode, a strobe held high ignoring later bus changes, reset clearing registers that had been loaded, and the full sweep of the sixteen enable, direction and select combinations against both live and stored data.

// File: rtl/xcvr_pkg.sv
// Package: shared types for the registered bus transceiver.
// Assumes side index 0 is bus A and side index 1 is bus B.
package xcvr_pkg;

    // Which side the transceiver is currently driving.
    typedef enum logic [1:0] {
        DRIVE_NONE = 2'd0,
        DRIVE_A    = 2'd1,
        DRIVE_B    = 2'd2
    } drive_side_e;

    localparam int NUM_SIDES = 2;
    localparam int SIDE_A    = 0;
    localparam int SIDE_B    = 1;

endpackage

// File: rtl/xcvr_capture_reg.sv
// Module: xcvr_capture_reg
// Holds one side's stored bus value. The capture strobe is sampled on the
// system clock and its low-to-high change loads the register.
// Assumes the strobe is already synchronous to clk. Reset is synchronous,
// active low, and clears both the data and the strobe history.
module xcvr_capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [WIDTH-1:0] bus_i,
    output logic [WIDTH-1:0] store_o
);

    logic cap_q;
    logic load;

    // Detect a rising strobe relative to the previous sample.
    always_comb begin
        load = cap_i & ~cap_q;
    end

    // Track the strobe history and load the register on a detected edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q   <= 1'b0;
            store_o <= '0;
        end else begin
            cap_q <= cap_i;
            if (load) begin
                store_o <= bus_i;
            end
        end
    end

    // R1 and R2: a fresh strobe edge loads the bus value.
    assert_capture_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cap_i && !$past(cap_i)) |=> (store_o == $past(bus_i)));

    // R11: a strobe held high leaves the register unchanged.
    assert_held_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cap_i && $past(cap_i)) |=> $stable(store_o));

    // R3: with no strobe edge the register keeps its value.
    assert_no_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_i) |=> $stable(store_o));

endmodule

// File: rtl/xcvr_drive_path.sv
// Module: xcvr_drive_path
// Builds the output value and enable vector for one side. It chooses
// between the opposite bus (live) and the opposite side's register (stored).
// Assumes drive_i is already qualified by enable and direction.
// Outputs are zero whenever the side is not driven.
module xcvr_drive_path #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drive_i,
    input  logic             sel_stored_i,
    input  logic [WIDTH-1:0] live_i,
    input  logic [WIDTH-1:0] stored_i,
    output logic [WIDTH-1:0] out_o,
    output logic [WIDTH-1:0] oe_o
);

    logic [WIDTH-1:0] src;

    // Pick the live or stored source.
    always_comb begin
        src = sel_stored_i ? stored_i : live_i;
    end

    // Gate the value and spread the drive flag over every bit.
    always_comb begin
        out_o = drive_i ? src : '0;
        oe_o  = {WIDTH{drive_i}};
    end

    // R9: the enable vector is uniform and the data is zero when not driven.
    assert_oe_uniform_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((oe_o == '0) || (oe_o == '1)) && ((oe_o != '0) || (out_o == '0)));

endmodule

// File: rtl/bus_xcvr_reg.sv
// Module: bus_xcvr_reg (top)
// Registered bidirectional transceiver between bus A and bus B.
// Each side owns a capture register loaded on its strobe's rising edge.
// The enable and direction inputs decide which side is driven, and each
// direction's select picks a live or stored source.
// Assumes all inputs are synchronous to clk. Reset is synchronous, active low.
module bus_xcvr_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    input  logic             cap_a,
    input  logic             cap_b,
    input  logic             oe_n,
    input  logic             dir_a2b,
    input  logic             sel_a2b,
    input  logic             sel_b2a
);
    import xcvr_pkg::*;

    drive_side_e side;

    logic [NUM_SIDES-1:0][WIDTH-1:0] bus_in;
    logic [NUM_SIDES-1:0][WIDTH-1:0] stored;
    logic [NUM_SIDES-1:0][WIDTH-1:0] drv_out;
    logic [NUM_SIDES-1:0][WIDTH-1:0] drv_oe;
    logic [NUM_SIDES-1:0]            cap;
    logic [NUM_SIDES-1:0]            sel;
    logic [NUM_SIDES-1:0]            drive;

    // Decode enable and direction into the driven side.
    always_comb begin
        if (oe_n) begin
            side = DRIVE_NONE;
        end else if (dir_a2b) begin
            side = DRIVE_B;
        end else begin
            side = DRIVE_A;
        end
    end

    // Arrange the per-side inputs by side index.
    always_comb begin
        bus_in[SIDE_A] = a_in;
        bus_in[SIDE_B] = b_in;
        cap[SIDE_A]    = cap_a;
        cap[SIDE_B]    = cap_b;
        sel[SIDE_A]    = sel_b2a;
        sel[SIDE_B]    = sel_a2b;
        drive[SIDE_A]  = (side == DRIVE_A);
        drive[SIDE_B]  = (side == DRIVE_B);
    end

    // One capture register and one drive path per side. A side is driven
    // from the opposite side's bus or register.
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        xcvr_capture_reg #(.WIDTH(WIDTH)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_i   (cap[s]),
            .bus_i   (bus_in[s]),
            .store_o (stored[s])
        );

        xcvr_drive_path #(.WIDTH(WIDTH)) u_drv (
            .clk          (clk),
            .rst_n        (rst_n),
            .drive_i      (drive[s]),
            .sel_stored_i (sel[s]),
            .live_i       (bus_in[NUM_SIDES-1-s]),
            .stored_i     (stored[NUM_SIDES-1-s]),
            .out_o        (drv_out[s]),
            .oe_o         (drv_oe[s])
        );
    end

    // Map the side arrays back onto the named ports.
    always_comb begin
        a_out = drv_out[SIDE_A];
        a_oe  = drv_oe[SIDE_A];
        b_out = drv_out[SIDE_B];
        b_oe  = drv_oe[SIDE_B];
    end

    // R4: isolation drives neither side.
    assert_isolation_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

    // R5 and R6: never both sides driven at once.
    assert_single_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !((a_oe != '0) && (b_oe != '0)));

    // R6: direction low with enable drives only A.
    assert_drive_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !dir_a2b) |-> (a_oe == '1 && b_oe == '0));

    // R7: stored mode toward B shows the A register.
    assert_stored_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && dir_a2b && sel_a2b) |-> (b_out == stored[SIDE_A]));

    // R8: stored mode toward A shows the B register.
    assert_stored_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !dir_a2b && sel_b2a) |-> (a_out == stored[SIDE_B]));

endmodule

// File: tb/sim_bus_xcvr_reg.sv
`timescale 1ns/1ps
// Scoreboard bench for bus_xcvr_reg. A driver task applies one cycle of
// stimulus, computes the expected outputs from its own model and queues
// them. A monitor pops each item and compares it with the ports.
module sim_bus_xcvr_reg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         cap_a = 1'b0, cap_b = 1'b0, oe_n = 1'b1;
    logic         dir_a2b = 1'b0, sel_a2b = 1'b0, sel_b2a = 1'b0;

    typedef struct {
        logic [W-1:0] a_out, a_oe, b_out, b_oe;
        string        tag;
    } exp_t;

    exp_t         exp_q[$];
    logic [W-1:0] m_reg_a = '0, m_reg_b = '0;
    logic         m_prev_a = 1'b0, m_prev_b = 1'b0;
    int           checks = 0, failures = 0;
    bit           done = 0;

    always #2 clk = ~clk;

    bus_xcvr_reg #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .cap_a(cap_a), .cap_b(cap_b), .oe_n(oe_n), .dir_a2b(dir_a2b),
        .sel_a2b(sel_a2b), .sel_b2a(sel_b2a)
    );

    // One cycle: drive at the falling edge, queue the expected outputs,
    // then advance the model as the next rising edge will.
    task automatic step(input logic rst_v, input logic g, input logic d,
                        input logic sab, input logic sba, input logic ca,
                        input logic cb, input logic [W-1:0] av,
                        input logic [W-1:0] bv, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rst_v; oe_n = g; dir_a2b = d; sel_a2b = sab; sel_b2a = sba;
        cap_a = ca; cap_b = cb; a_in = av; b_in = bv;
        #0.5;
        e.a_out = '0; e.a_oe = '0; e.b_out = '0; e.b_oe = '0; e.tag = tag;
        if (!g && d) begin
            e.b_oe  = '1;
            e.b_out = sab ? m_reg_a : av;
        end else if (!g && !d) begin
            e.a_oe  = '1;
            e.a_out = sba ? m_reg_b : bv;
        end
        exp_q.push_back(e);
        if (!rst_v) begin
            m_reg_a = '0; m_reg_b = '0; m_prev_a = 1'b0; m_prev_b = 1'b0;
        end else begin
            if (ca && !m_prev_a) m_reg_a = av;
            if (cb && !m_prev_b) m_reg_b = bv;
            m_prev_a = ca; m_prev_b = cb;
        end
    endtask

    // Monitor: compare every queued expectation with the ports.
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            checks++;
            if (a_out !== e.a_out || a_oe !== e.a_oe ||
                b_out !== e.b_out || b_oe !== e.b_oe) begin
                failures++;
                $display("FAIL %s: a_out=%h a_oe=%h b_out=%h b_oe=%h expected a_out=%h a_oe=%h b_out=%h b_oe=%h",
                         e.tag, a_out, a_oe, b_out, b_oe,
                         e.a_out, e.a_oe, e.b_out, e.b_oe);
            end
        end
    end

    // Sweep all sixteen control combinations with the given bus data.
    task automatic sweep(input logic [W-1:0] av, input logic [W-1:0] bv);
        for (int k = 0; k < 16; k++) begin
            logic g, d, sab, sba;
            string t;
            {g, d, sab, sba} = 4'(k);
            if (g)       t = "R4 R9 isolation";
            else if (d)  t = sab ? "R5 R7 stored A->B" : "R5 R7 live A->B";
            else         t = sba ? "R6 R8 stored B->A" : "R6 R8 live B->A";
            step(1'b1, g, d, sab, sba, 1'b0, 1'b0, av, bv, t);
        end
    endtask

    initial begin
        // R10: reset state, registers read as zero through stored paths.
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R10 in reset");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R10 in reset");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, "R10 A reg zero");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22, "R10 B reg zero");
        // Full sweep with registers at zero.
        sweep(8'h3C, 8'hA5);
        // R3: capture on both sides while isolated.
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hC3, "R3 capture isolated");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R3 R4 isolated");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, "R1 R3 stored A 5A");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, "R2 R3 stored B C3");
        // R11: strobe held high while the bus changes.
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 8'h00, "R1 capture 81");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h42, 8'h00, "R11 held strobe keeps 81");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h24, 8'h00, "R11 held strobe keeps 81");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h99, 8'h00, "R11 released");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h66, 8'h00, "R1 recapture 66");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R1 R7 stored 66");
        // R2 with R8: capture while the stored B->A path is enabled.
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h7E, "R2 capture 7E");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h01, "R2 R8 stored 7E");
        // Full sweep with nonzero registers and fresh bus data.
        sweep(8'hE7, 8'h18);
        // R10: reset clears loaded registers.
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R10 reset again");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hAA, 8'hBB, "R10 A cleared");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hAA, 8'hBB, "R10 B cleared");
        @(negedge clk);
        wait (exp_q.size() == 0);
        #1;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule